// File: doc/BRIEF.md
# Seven-Level Staircase Phase Modulator

This block drives one phase of a converter built from three series-connected full-bridge cells. Each switching period it takes a signed reference voltage and turns it into a target phase level between -3 and +3, in units of the cell voltage. The block works out which pair of neighbouring levels brackets the reference. It then computes how long each of the two levels must be held so that their time-weighted average equals the reference. A symmetric triangular carrier spreads those two dwell times across the period. The output is the level for each clock tick, plus a strobe that marks every change of level. A later stage picks the cells that produce the level.

Each period begins at the carrier valley. At that point the block captures the reference magnitude and sign, the cell voltage, the period length and a precomputed reciprocal. The reciprocal is the period length divided by the cell voltage, as an unsigned fixed-point value with `FRAC_W` fractional bits. These values stay fixed until the next period begins, so the dwell times never move inside a period. The datapath uses only comparisons and one multiply, and contains no divider. References at or beyond three cell voltages are saturated.

Top module: `stair_modulator`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `phaseLevel` is 0 and `levelStep` is 0.
- R2: A period of `Ts` ticks starts at the edge after reset release and again every `Ts` clock cycles, where `Ts` is the `periodTicks` value captured at the start of that period (`Ts` of at least 2). The inputs `refMag`, `refNeg`, `cellVolt`, `periodTicks` and `tsPerVolt` are captured only at period starts. A change of any of them inside a period has no effect on that period's levels.
- R3: At tick t of a period (t = 0 .. Ts-1), the carrier is 2t when 2t <= Ts and 2Ts-2t otherwise. It is 0 at the valley and reaches Ts at its peak.
- R4: The magnitude region k is 2 when V >= 2U, 1 when U <= V < 2U, and 0 otherwise, where V is the captured magnitude and U is the captured cell voltage. When V < 3U, each tick outputs only magnitude k or k+1.
- R5: The upper-level dwell is floor((V - k*U) * R / 2^FRAC_W), where R is the captured reciprocal. The lower-level dwell D is Ts minus the upper dwell, so the two always sum to Ts.
- R6: At each tick the lower level k is chosen when D >= carrier, and the upper level k+1 otherwise.
- R7: When the captured sign `refNeg` is 1, the output is the negation of the magnitude level chosen above, and a magnitude of 0 is output as 0.
- R8: When V >= 3U, the magnitude level is 3 on every tick of the period, whatever the carrier.
- R9: An upper dwell larger than Ts is clamped to Ts, which makes D = 0.
- R10: `phaseLevel` is a 3-bit two's-complement number. The level for tick t appears during the clock cycle that follows the edge ending tick t.
- R11: `levelStep` is 1 in exactly those cycles in which `phaseLevel` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refMag | input | REF_W (12) | Reference magnitude, in the same unit as `cellVolt` |
| refNeg | input | 1 | Reference sign, 1 for negative |
| cellVolt | input | REF_W (12) | Nominal cell voltage U |
| periodTicks | input | TS_W (10) | Switching period Ts in clock ticks |
| tsPerVolt | input | RECIP_W (16) | Ts/U as fixed point with FRAC_W (8) fractional bits |
| phaseLevel | output | LVL_W (3) | Signed target phase level, -3 to +3 |
| levelStep | output | 1 | One-cycle strobe on every level change |

## Verification
The hardest case to reach is an input change in the middle of a period. The block must ignore it until the next valley, and the new period length must take effect exactly at that boundary. The stimulus loads every next vector halfway through the current period, including vectors that change the period from 100 to 40 ticks. Every tick of every period is then checked against the expected carrier comparison. The clamp case needs a reciprocal that does not match the period and cell voltage. One vector supplies such a reciprocal on purpose, so that the upper dwell overflows to Ts.

// File: rtl/stair_pkg.sv
package stair_pkg;

  // Strobes from the period controller to the datapath.
  typedef struct packed {
    logic load;  // last tick of a period: capture inputs at this edge
    logic live;  // a captured period is running
  } stair_ctl_t;

endpackage

// File: rtl/stair_ctrl.sv
module stair_ctrl
  import stair_pkg::*;
#(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TS_W-1:0] periodTicks,
  output stair_ctl_t      ctl,
  output logic [TS_W:0]   carrier,
  output logic [TS_W-1:0] tsHeld
);

  localparam logic [TS_W:0] ONE_W = 1;

  logic [TS_W-1:0] phase;
  logic            running;
  logic            endOfPeriod;
  logic [TS_W:0]   twoPhase;
  logic [TS_W:0]   twoTs;

  // With tsHeld at 0 after reset this fires at once and starts the first period.
  assign endOfPeriod = ({1'b0, phase} + ONE_W) >= {1'b0, tsHeld};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      tsHeld  <= '0;
      running <= 1'b0;
    end else if (endOfPeriod) begin
      phase   <= '0;
      tsHeld  <= periodTicks;
      running <= 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Symmetric triangle: valley at tick 0, peak Ts at mid-period.
  assign twoPhase = {phase, 1'b0};
  assign twoTs    = {tsHeld, 1'b0};
  assign carrier  = (twoPhase <= {1'b0, tsHeld}) ? twoPhase : (twoTs - twoPhase);

  assign ctl.load = endOfPeriod;
  assign ctl.live = running;

  AST_CARRIER_PEAK: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (carrier <= {1'b0, tsHeld})) else $error("carrier above peak"); // R3

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    endOfPeriod |=> (phase == '0) && (carrier == '0)) else $error("no valley after period end"); // R2

  AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (phase < tsHeld)) else $error("tick index past period"); // R2

endmodule

// File: rtl/stair_dpath.sv
module stair_dpath
  import stair_pkg::*;
#(
  parameter int CELLS   = 3,
  parameter int REF_W   = 12,
  parameter int TS_W    = 10,
  parameter int RECIP_W = 16,
  parameter int FRAC_W  = 8,
  localparam int CNT_W  = $clog2(CELLS + 1),
  localparam int LVL_W  = CNT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stair_ctl_t         ctl,
  input  logic [TS_W:0]      carrier,
  input  logic [TS_W-1:0]    tsHeld,
  input  logic [REF_W-1:0]   refMag,
  input  logic               refNeg,
  input  logic [REF_W-1:0]   cellVolt,
  input  logic [RECIP_W-1:0] tsPerVolt,
  output logic [LVL_W-1:0]   phaseLevel,
  output logic               levelStep
);

  localparam int THR_W  = REF_W + CNT_W;
  localparam int PROD_W = REF_W + RECIP_W;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [LVL_W-1:0] LVL_ONE = 1;

  // Values held for the whole period.
  logic [REF_W-1:0]   magQ;
  logic [REF_W-1:0]   voltQ;
  logic               negQ;
  logic [RECIP_W-1:0] recipQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      magQ   <= '0;
      voltQ  <= '0;
      negQ   <= 1'b0;
      recipQ <= '0;
    end else if (ctl.load) begin
      magQ   <= refMag;
      voltQ  <= cellVolt;
      negQ   <= refNeg;
      recipQ <= tsPerVolt;
    end
  end

  // Threshold ladder: thr[g] = g * U, reached[g] = V >= g * U.
  logic [THR_W-1:0] thr [CELLS+1];
  logic [CELLS:1]   reached;

  assign thr[0] = '0;

  for (genvar g = 1; g <= CELLS; g++) begin : g_thr
    assign thr[g]     = THR_W'(voltQ) * THR_W'(g);
    assign reached[g] = THR_W'(magQ) >= thr[g];
  end

  logic [CNT_W-1:0]  region;
  logic              saturated;
  logic [REF_W-1:0]  resid;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] scaled;
  logic [TS_W-1:0]   dwellUp;
  logic [TS_W-1:0]   dwellLow;
  logic              pickLower;
  logic [CNT_W-1:0]  magLevel;
  logic [LVL_W-1:0]  unsignedLvl;
  logic [LVL_W-1:0]  levelNext;

  always_comb begin
    region = '0;
    for (int i = 1; i < CELLS; i++) begin
      region = region + CNT_W'(reached[i]);
    end
  end

  assign saturated = reached[CELLS];
  assign resid     = REF_W'(THR_W'(magQ) - thr[region]);
  assign product   = PROD_W'(resid) * PROD_W'(recipQ);
  assign scaled    = product >> FRAC_W;
  assign dwellUp   = (scaled > PROD_W'(tsHeld)) ? tsHeld : scaled[TS_W-1:0];
  assign dwellLow  = tsHeld - dwellUp;
  assign pickLower = {1'b0, dwellLow} >= carrier;

  assign magLevel    = saturated ? CNT_W'(CELLS) : (pickLower ? region : region + CNT_ONE);
  assign unsignedLvl = {1'b0, magLevel};
  assign levelNext   = negQ ? (~unsignedLvl + LVL_ONE) : unsignedLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseLevel <= '0;
      levelStep  <= 1'b0;
    end else if (ctl.live) begin
      phaseLevel <= levelNext;
      levelStep  <= levelNext != phaseLevel;
    end else begin
      levelStep <= 1'b0;
    end
  end

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(magQ) && $stable(negQ) && $stable(voltQ) && $stable(recipQ))
    else $error("held reference moved inside a period"); // R2

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(phaseLevel) <= CELLS) && ($signed(phaseLevel) >= -CELLS))
    else $error("level out of range"); // R4

  AST_DWELL_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.live |-> (dwellUp <= tsHeld)) else $error("upper dwell exceeds period"); // R9

  AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.live && saturated) |=> (($signed(phaseLevel) == CELLS) || ($signed(phaseLevel) == -CELLS)))
    else $error("saturated reference not at full level"); // R8

  AST_NEG_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.live && negQ) |=> ($signed(phaseLevel) <= 0)) else $error("negative reference gave positive level"); // R7

  AST_STEP_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    levelStep |-> (phaseLevel != $past(phaseLevel))) else $error("strobe without level change"); // R11

endmodule

// File: rtl/stair_modulator.sv
module stair_modulator
  import stair_pkg::*;
#(
  parameter int CELLS   = 3,
  parameter int REF_W   = 12,
  parameter int TS_W    = 10,
  parameter int RECIP_W = 16,
  parameter int FRAC_W  = 8,
  localparam int CNT_W  = $clog2(CELLS + 1),
  localparam int LVL_W  = CNT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [REF_W-1:0]   refMag,
  input  logic               refNeg,
  input  logic [REF_W-1:0]   cellVolt,
  input  logic [TS_W-1:0]    periodTicks,
  input  logic [RECIP_W-1:0] tsPerVolt,
  output logic [LVL_W-1:0]   phaseLevel,
  output logic               levelStep
);

  stair_ctl_t      ctl;
  logic [TS_W:0]   carrier;
  logic [TS_W-1:0] tsHeld;

  stair_ctrl #(
    .TS_W(TS_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodTicks(periodTicks),
    .ctl        (ctl),
    .carrier    (carrier),
    .tsHeld     (tsHeld)
  );

  stair_dpath #(
    .CELLS  (CELLS),
    .REF_W  (REF_W),
    .TS_W   (TS_W),
    .RECIP_W(RECIP_W),
    .FRAC_W (FRAC_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .carrier   (carrier),
    .tsHeld    (tsHeld),
    .refMag    (refMag),
    .refNeg    (refNeg),
    .cellVolt  (cellVolt),
    .tsPerVolt (tsPerVolt),
    .phaseLevel(phaseLevel),
    .levelStep (levelStep)
  );

endmodule

// File: tb/stair_modulator_test.sv
module stair_modulator_test;

  localparam int NV = 14;
  localparam int UCELL = 256;

  // Vector table: magnitude, sign, period, reciprocal, expected lower dwell D,
  // expected lower and upper signed levels.
  localparam int V_MAG [NV] = '{0,   128, 300, 600, 768, 1000, 255, 256, 400, 512, 128, 700, 200, 64};
  localparam int V_NEG [NV] = '{0,   0,   0,   1,   0,   1,    0,   0,   1,   0,   0,   1,   0,   1};
  localparam int V_TS  [NV] = '{100, 100, 100, 100, 100, 100,  100, 100, 100, 100, 40,  40,  40,  40};
  localparam int V_RCP [NV] = '{100, 100, 100, 100, 100, 100,  100, 100, 100, 100, 40,  40,  80,  40};
  localparam int V_D   [NV] = '{100, 50,  83,  66,  100, 100,  1,   100, 44,  100, 20,  11,  0,   30};
  localparam int V_LO  [NV] = '{0,   0,   1,   -2,  3,   -3,   0,   1,   -1,  2,   0,   -2,  0,   0};
  localparam int V_HI  [NV] = '{1,   1,   2,   -3,  3,   -3,   1,   2,   -2,  3,   1,   -3,  1,   -1};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] refMag = '0;
  logic        refNeg = 1'b0;
  logic [11:0] cellVolt = '0;
  logic [9:0]  periodTicks = '0;
  logic [15:0] tsPerVolt = '0;
  logic [2:0]  phaseLevel;
  logic        levelStep;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stair_modulator uut (
    .clk        (clk),
    .rstN       (rstN),
    .refMag     (refMag),
    .refNeg     (refNeg),
    .cellVolt   (cellVolt),
    .periodTicks(periodTicks),
    .tsPerVolt  (tsPerVolt),
    .phaseLevel (phaseLevel),
    .levelStep  (levelStep)
  );

  function automatic string vecTag(int i);
    case (i)
      0, 7, 9: vecTag = "R4 R5 R6 (zero residue)";
      1, 2, 6: vecTag = "R3 R4 R5 R6";
      3, 8:    vecTag = "R7 R4 R6";
      4:       vecTag = "R8";
      5:       vecTag = "R8 R7";
      10, 11:  vecTag = "R2 R3 R6 (new period length)";
      12:      vecTag = "R9";
      default: vecTag = "R7 (negative zero)";
    endcase
  endfunction

  function automatic int carrierAt(int t, int ts);
    carrierAt = (2 * t <= ts) ? 2 * t : 2 * ts - 2 * t;
  endfunction

  task automatic applyVec(int i);
    refMag      = 12'(V_MAG[i]);
    refNeg      = V_NEG[i][0];
    cellVolt    = 12'(UCELL);
    periodTicks = 10'(V_TS[i]);
    tsPerVolt   = 16'(V_RCP[i]);
  endtask

  task automatic checkInt(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    int prevLvl;
    int expLvl;
    int lowTicks;
    applyVec(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkInt("R1 level in reset", $signed(phaseLevel), 0);
    checkInt("R1 strobe in reset", int'(levelStep), 0);
    rstN = 1'b1;
    @(posedge clk);  // first period load edge
    @(negedge clk);
    checkInt("R1 level at start", $signed(phaseLevel), 0);
    checkInt("R1 strobe at start", int'(levelStep), 0);
    prevLvl = 0;
    for (int v = 0; v < NV; v++) begin
      lowTicks = 0;
      for (int t = 0; t < V_TS[v]; t++) begin
        @(posedge clk);
        @(negedge clk);
        // R10: level for tick t shows one cycle after that tick.
        expLvl = (carrierAt(t, V_TS[v]) <= V_D[v]) ? V_LO[v] : V_HI[v];
        if (expLvl == V_LO[v]) lowTicks++;
        checkInt($sformatf("%s R10 vec %0d tick %0d level", vecTag(v), v, t),
                 $signed(phaseLevel), expLvl);
        checkInt($sformatf("R11 vec %0d tick %0d strobe", v, t),
                 int'(levelStep), int'($signed(phaseLevel) != prevLvl));
        prevLvl = $signed(phaseLevel);
        // R2: next vector arrives mid-period and must not disturb this one.
        if (t == V_TS[v] / 2 && v + 1 < NV) applyVec(v + 1);
      end
      // R5: lower-level ticks follow from D on the symmetric carrier.
      if (V_LO[v] != V_HI[v]) begin
        checkInt($sformatf("R5 vec %0d lower tick count", v), lowTicks,
                 (V_D[v] >= V_TS[v]) ? V_TS[v] : 1 + 2 * (V_D[v] / 2));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule